// File: doc/BRIEF.md
# Bank-Interleaved Cache-Line Read Controller

This block sits at the front of a memory controller. It accepts cache-line read requests and turns each one into row and column commands for a set of independent banks. A request address holds a row, a bank and a column. The block keeps track of the row that is open in each bank. A request that finds its row already open goes straight to the column command. A request to a bank with no open row first activates one. A request to a bank with a different row open first closes that row with a precharge, then activates the new one. One column command starts an eight-beat burst of 64-bit beats. The block packs those beats into one 512-bit line and returns it.

Each bank works through its own precharge and activation timing. The shared command port gives a column command priority whenever the data bus is free. A bank that is waiting out its row-to-column delay therefore does not hold up a burst from another bank whose row is ready. Column commands go out in the order the requests arrived, so lines come back in that order too. A new request is accepted whenever its target bank has no request pending. A request that targets a busy bank waits at the port and does not affect the other banks.

Top module: `line_fetch_ctrl`

## Requirements
- R1: The request address is laid out as row in the top ROW_W bits, bank in the next BANK_W bits, and column in the low COL_W bits. A column command carries the request's row and its column with the low log2(BURST) bits forced to zero, so the burst starts on an eight-beat boundary.
- R2: A request to a bank with no open row produces exactly one activate (cmd_kind 1) and then one column read (cmd_kind 2) to that bank, with no precharge in between.
- R3: A column read to a bank is issued at least T_RCD cycles after that bank's most recent activate.
- R4: A request whose row matches the bank's open row produces a column read with no precharge or activate to that bank.
- R5: A request to a bank with a different row open produces one precharge (cmd_kind 3), then one activate at least T_RP cycles later, then the column read. A bank is never activated while a row is open in it.
- R6: Two column reads are at least BURST cycles apart, so bursts never overlap on the data bus.
- R7: An activate to one bank may be issued while another bank's burst is in progress, within BURST cycles of that bank's column read.
- R8: Column reads go out in the same bank order as the requests were accepted.
- R9: Beats fill the line in arrival order, the first beat occupying bits 63:0. line_valid rises in the cycle after the eighth beat and stays high for one cycle only.
- R10: req_ready is low while the addressed bank holds a request that has not yet issued its column read, and high for an addressed bank that holds none.
- R11: During and right after reset no command is issued and line_valid is low, every bank starts with no open row, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A read request is offered |
| req_ready | output | 1 | The request is taken on this edge |
| req_addr | input | ROW_W+BANK_W+COL_W | Row, bank and column of the line to read |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 2 | 1 activate, 2 column read, 3 precharge |
| cmd_bank | output | BANK_W | Bank the command targets |
| cmd_row | output | ROW_W | Row opened, read or closed |
| cmd_col | output | COL_W | Starting column of a read, zero otherwise |
| beat_valid | input | 1 | A data beat is present |
| beat_data | input | BEAT_W | Data beat, byte lane k in bits 8k+7:8k |
| line_valid | output | 1 | One-cycle pulse, the line is complete |
| line_data | output | BURST*BEAT_W | Assembled line, first beat lowest |

## Verification
The bench builds the block with four banks, a 4-bit row field, a 6-bit column field, T_RCD of 6, T_RP of 3 and an eight-beat burst. The narrow row field, with rows drawn from only three values, makes row hits, first activations and row conflicts all common under random traffic. T_RCD is set shorter than the burst, so a second bank's activation fits inside an active burst, and the overlap and the column-spacing limit can both be seen in one short sequence. A memory model answers each column read three cycles later with beats that encode bank, row, column and beat index. A wrong row, column or beat order therefore shows up directly in the assembled line.

// File: rtl/lfc_pkg.sv
// Shared encodings for the line fetch controller.
// Assumes: command code values are visible at the port and must not change.
package lfc_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_kind_t;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_NEED_PRE,
        BK_PRE_WAIT,
        BK_NEED_ACT,
        BK_ACT_WAIT,
        BK_READY
    } bank_st_t;

endpackage

// File: rtl/bank_fsm.sv
// Per-bank sequencer. It holds one pending request and the bank's open-row
// register. On load it decides among hit, closed and conflict, raises requests
// for precharge or activate, counts out T_RP and T_RCD, and then reports ready.
// Assumes: grants arrive only for the command the bank is requesting.
module bank_fsm
    import lfc_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 8,
    parameter int T_RCD = 4,
    parameter int T_RP  = 3,
    localparam int MAX_T = (T_RCD > T_RP) ? T_RCD : T_RP,
    localparam int CNT_W = $clog2(MAX_T + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [ROW_W-1:0] load_row_i,
    input  logic [COL_W-1:0] load_col_i,
    input  logic             grant_pre_i,
    input  logic             grant_act_i,
    input  logic             grant_rd_i,
    output logic             idle_o,
    output logic             need_pre_o,
    output logic             need_act_o,
    output logic             ready_o,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o
);

    bank_st_t         st;
    logic [CNT_W-1:0] cnt;
    logic             open_vld;
    logic [ROW_W-1:0] open_row;
    logic [ROW_W-1:0] tgt_row;
    logic [COL_W-1:0] tgt_col;

    // Step the bank through close, open and wait phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= BK_IDLE;
            cnt      <= '0;
            open_vld <= 1'b0;
            open_row <= '0;
            tgt_row  <= '0;
            tgt_col  <= '0;
        end else begin
            case (st)
                BK_IDLE: if (load_i) begin
                    tgt_row <= load_row_i;
                    tgt_col <= load_col_i;
                    if (open_vld && open_row == load_row_i) st <= BK_READY;
                    else if (open_vld)                      st <= BK_NEED_PRE;
                    else                                    st <= BK_NEED_ACT;
                end
                BK_NEED_PRE: if (grant_pre_i) begin
                    st       <= BK_PRE_WAIT;
                    cnt      <= CNT_W'(T_RP - 1);
                    open_vld <= 1'b0;
                end
                BK_PRE_WAIT: begin
                    if (cnt == '0) st <= BK_NEED_ACT;
                    else           cnt <= cnt - 1'b1;
                end
                BK_NEED_ACT: if (grant_act_i) begin
                    st       <= BK_ACT_WAIT;
                    cnt      <= CNT_W'(T_RCD - 1);
                    open_vld <= 1'b1;
                    open_row <= tgt_row;
                end
                BK_ACT_WAIT: begin
                    if (cnt == '0) st <= BK_READY;
                    else           cnt <= cnt - 1'b1;
                end
                BK_READY: if (grant_rd_i) st <= BK_IDLE;
                default: st <= BK_IDLE;
            endcase
        end
    end

    // Report the phase and the row this bank wants on the command port.
    always_comb begin
        idle_o     = (st == BK_IDLE);
        need_pre_o = (st == BK_NEED_PRE);
        need_act_o = (st == BK_NEED_ACT);
        ready_o    = (st == BK_READY);
        row_o      = (st == BK_NEED_PRE) ? open_row : tgt_row;
        col_o      = tgt_col;
    end

endmodule

// File: rtl/order_fifo.sv
// Small FIFO of bank numbers that records request arrival order.
// Assumes: the producer never pushes when full (one entry per busy bank).
module order_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o
);

    logic [W-1:0]     mem [DEPTH];
    logic [IDX_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store entries and move pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) begin
                mem[wr_ptr] <= push_data_i;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop_i) rd_ptr <= bump(rd_ptr);
            case ({push_i, pop_i})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_o  = mem[rd_ptr];
    assign empty_o = (count == '0);

endmodule

// File: rtl/line_assembler.sv
// Gathers BURST beats into one line, first beat in the lowest slice, and
// pulses line_valid in the cycle after the last beat.
// Assumes: bursts arrive whole and never interleave.
module line_assembler #(
    parameter int BEAT_W = 64,
    parameter int BURST  = 8,
    localparam int IDX_W  = $clog2(BURST),
    localparam int LINE_W = BEAT_W * BURST
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid_i,
    input  logic [BEAT_W-1:0] beat_data_i,
    output logic              line_valid_o,
    output logic [LINE_W-1:0] line_data_o
);

    logic [IDX_W-1:0] idx;

    // Count beats and flag the completed line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx          <= '0;
            line_valid_o <= 1'b0;
        end else begin
            line_valid_o <= 1'b0;
            if (beat_valid_i) begin
                if (idx == IDX_W'(BURST - 1)) begin
                    idx          <= '0;
                    line_valid_o <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < BURST; g++) begin : g_slot
        logic [BEAT_W-1:0] slot_q;
        // Capture the beat that belongs to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  slot_q <= '0;
            else if (beat_valid_i && idx == IDX_W'(g))   slot_q <= beat_data_i;
        end
        assign line_data_o[g*BEAT_W +: BEAT_W] = slot_q;
    end

endmodule

// File: rtl/line_fetch_ctrl.sv
// Top of the cache-line read controller. It decodes request addresses, hands
// each request to its bank sequencer, arbitrates the single command port
// (in-order column reads first, then precharge/activate by lowest bank),
// spaces column reads by the burst length and assembles returned beats.
// Assumes: NUM_BANKS is a power of two; read data returns in command order.
module line_fetch_ctrl
    import lfc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 8,
    parameter int T_RCD     = 4,
    parameter int T_RP      = 3,
    parameter int BURST     = 8,
    parameter int BEAT_W    = 64,
    localparam int BANK_W  = $clog2(NUM_BANKS),
    localparam int ADDR_W  = ROW_W + BANK_W + COL_W,
    localparam int LINE_W  = BURST * BEAT_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_data,
    output logic              line_valid,
    output logic [LINE_W-1:0] line_data
);

    localparam int ALIGN_W = $clog2(BURST);
    localparam int GAP_W   = $clog2(BURST + 1);

    logic [COL_W-1:0]     req_col;
    logic [BANK_W-1:0]    req_bank;
    logic [ROW_W-1:0]     req_row;
    logic                 accept;
    logic [NUM_BANKS-1:0] bank_idle, need_pre, need_act, bank_rdy;
    logic [NUM_BANKS-1:0] g_pre, g_act, g_rd;
    logic [ROW_W-1:0]     bank_row [NUM_BANKS];
    logic [COL_W-1:0]     bank_col [NUM_BANKS];
    logic [BANK_W-1:0]    head, sel;
    logic                 fifo_empty, rd_go, found;
    logic [GAP_W-1:0]     gap_cnt;
    cmd_kind_t            kind_sel;

    assign req_col   = req_addr[COL_W-1:0];
    assign req_bank  = req_addr[COL_W +: BANK_W];
    assign req_row   = req_addr[ADDR_W-1 -: ROW_W];
    assign req_ready = bank_idle[req_bank];
    assign accept    = req_valid && req_ready;
    assign cmd_kind  = kind_sel;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        bank_fsm #(
            .ROW_W (ROW_W),
            .COL_W (COL_W),
            .T_RCD (T_RCD),
            .T_RP  (T_RP)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (accept && req_bank == BANK_W'(g)),
            .load_row_i  (req_row),
            .load_col_i  ({req_col[COL_W-1:ALIGN_W], ALIGN_W'(0)}),
            .grant_pre_i (g_pre[g]),
            .grant_act_i (g_act[g]),
            .grant_rd_i  (g_rd[g]),
            .idle_o      (bank_idle[g]),
            .need_pre_o  (need_pre[g]),
            .need_act_o  (need_act[g]),
            .ready_o     (bank_rdy[g]),
            .row_o       (bank_row[g]),
            .col_o       (bank_col[g])
        );
    end

    order_fifo #(
        .DEPTH (NUM_BANKS),
        .W     (BANK_W)
    ) u_order (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (accept),
        .push_data_i (req_bank),
        .pop_i       (rd_go),
        .head_o      (head),
        .empty_o     (fifo_empty)
    );

    // Pick one command per cycle: the oldest ready read, else the lowest bank
    // that needs a precharge or an activate.
    always_comb begin
        rd_go = !fifo_empty && bank_rdy[head] && (gap_cnt == '0);
        found = 1'b0;
        sel   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (!found && (need_pre[b] || need_act[b])) begin
                found = 1'b1;
                sel   = BANK_W'(b);
            end
        end
        g_rd      = '0;
        g_pre     = '0;
        g_act     = '0;
        cmd_valid = 1'b0;
        kind_sel  = CMD_NOP;
        cmd_bank  = '0;
        cmd_row   = '0;
        cmd_col   = '0;
        if (rd_go) begin
            g_rd[head] = 1'b1;
            cmd_valid  = 1'b1;
            kind_sel   = CMD_RD;
            cmd_bank   = head;
            cmd_row    = bank_row[head];
            cmd_col    = bank_col[head];
        end else if (found) begin
            cmd_valid = 1'b1;
            cmd_bank  = sel;
            cmd_row   = bank_row[sel];
            if (need_pre[sel]) begin
                g_pre[sel] = 1'b1;
                kind_sel   = CMD_PRE;
            end else begin
                g_act[sel] = 1'b1;
                kind_sel   = CMD_ACT;
            end
        end
    end

    // Hold off the next read until the current burst has left the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)              gap_cnt <= '0;
        else if (rd_go)          gap_cnt <= GAP_W'(BURST - 1);
        else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
    end

    line_assembler #(
        .BEAT_W (BEAT_W),
        .BURST  (BURST)
    ) u_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_valid_i (beat_valid),
        .beat_data_i  (beat_data),
        .line_valid_o (line_valid),
        .line_data_o  (line_data)
    );

endmodule

// File: rtl/lfc_checker.sv
// Protocol checker for line_fetch_ctrl, watching its ports only. It tracks a
// per-bank open flag and age counters and checks command legality and spacing.
// Assumes: attached by the bind statement at the end of this file.
module lfc_checker #(
    parameter int NUM_BANKS = 4,
    parameter int COL_W     = 8,
    parameter int T_RCD     = 4,
    parameter int T_RP      = 3,
    parameter int BURST     = 8,
    localparam int BANK_W  = $clog2(NUM_BANKS),
    localparam int ALIGN_W = $clog2(BURST)
)(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_kind,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [COL_W-1:0]  cmd_col,
    input logic              line_valid
);

    logic is_rd;
    int   rd_gap;

    assign is_rd = cmd_valid && cmd_kind == 2'd2;

    // Cycles since the last column read, saturating at BURST.
    always_ff @(posedge clk) begin
        if (!rst_n)              rd_gap <= BURST;
        else if (is_rd)          rd_gap <= 1;
        else if (rd_gap < BURST) rd_gap <= rd_gap + 1;
    end

    p_col_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> cmd_col[ALIGN_W-1:0] == '0);

    p_burst_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> rd_gap >= BURST);

    p_line_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |=> !line_valid);

    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!line_valid && !cmd_valid));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
        logic open_q, act_b, pre_b, rd_b;
        int   act_age, pre_age;

        assign act_b = cmd_valid && cmd_kind == 2'd1 && cmd_bank == BANK_W'(b);
        assign pre_b = cmd_valid && cmd_kind == 2'd3 && cmd_bank == BANK_W'(b);
        assign rd_b  = is_rd && cmd_bank == BANK_W'(b);

        // Follow the bank's open state and ages of its last open and close.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q  <= 1'b0;
                act_age <= T_RCD;
                pre_age <= T_RP;
            end else begin
                if (act_b)                open_q <= 1'b1;
                else if (pre_b)           open_q <= 1'b0;
                if (act_b)                act_age <= 1;
                else if (act_age < T_RCD) act_age <= act_age + 1;
                if (pre_b)                pre_age <= 1;
                else if (pre_age < T_RP)  pre_age <= pre_age + 1;
            end
        end

        p_rd_after_rcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_b |-> (open_q && act_age >= T_RCD));

        p_act_when_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
            act_b |-> (!open_q && pre_age >= T_RP));

        p_pre_when_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
            pre_b |-> open_q);
    end

endmodule

bind line_fetch_ctrl lfc_checker #(
    .NUM_BANKS (NUM_BANKS),
    .COL_W     (COL_W),
    .T_RCD     (T_RCD),
    .T_RP      (T_RP),
    .BURST     (BURST)
) u_lfc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .cmd_bank   (cmd_bank),
    .cmd_col    (cmd_col),
    .line_valid (line_valid)
);

// File: tb/line_fetch_ctrl_test.sv
// Scoreboard bench: the driver task pushes expected reads and lines, the
// negedge monitor plays the memory and compares commands and lines.
module line_fetch_ctrl_test;

    localparam int NB     = 4;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 6;
    localparam int T_RCD  = 6;
    localparam int T_RP   = 3;
    localparam int BURST  = 8;
    localparam int BEAT_W = 64;
    localparam int RD_LAT = 3;
    localparam int BANK_W = 2;
    localparam int ADDR_W = ROW_W + BANK_W + COL_W;
    localparam int LINE_W = BURST * BEAT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              cmd_valid;
    logic [1:0]        cmd_kind;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic [COL_W-1:0]  cmd_col;
    logic              beat_valid = 1'b0;
    logic [BEAT_W-1:0] beat_data = '0;
    logic              line_valid;
    logic [LINE_W-1:0] line_data;

    line_fetch_ctrl #(
        .NUM_BANKS (NB), .ROW_W (ROW_W), .COL_W (COL_W), .T_RCD (T_RCD),
        .T_RP (T_RP), .BURST (BURST), .BEAT_W (BEAT_W)
    ) uut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .cmd_valid (cmd_valid), .cmd_kind (cmd_kind),
        .cmd_bank (cmd_bank), .cmd_row (cmd_row), .cmd_col (cmd_col),
        .beat_valid (beat_valid), .beat_data (beat_data),
        .line_valid (line_valid), .line_data (line_data)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [BEAT_W-1:0] beat_val(input int b, input int r, input int c, input int i);
        return {8'hC3, 8'(i), 16'(b), 16'(r), 16'(c)};
    endfunction

    typedef struct { int bank; int row; int col; int cls; } req_t;
    typedef struct { int t; logic [BEAT_W-1:0] d; bit last; } beat_t;

    req_t              req_q[$];
    logic [LINE_W-1:0] line_q[$];
    beat_t             beat_q[$];
    int model_row[NB];
    int pre_n[NB], act_n[NB], pre_cyc[NB], act_cyc[NB], rd_cyc[NB];
    int last_rd   = -1000;
    int last_beat = -1000;
    bit prev_lv   = 1'b0;

    // Driver: offer one request, wait for acceptance, push expectations.
    task automatic send(input int b, input int r, input int c);
        int ca;
        int cls;
        logic [LINE_W-1:0] ln;
        ca = c - (c % BURST);
        req_valid = 1'b1;
        req_addr  = {ROW_W'(r), BANK_W'(b), COL_W'(c)};
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        if (model_row[b] < 0)       cls = 1;
        else if (model_row[b] == r) cls = 0;
        else                        cls = 2;
        model_row[b] = r;
        req_q.push_back('{bank: b, row: r, col: ca, cls: cls});
        for (int i = 0; i < BURST; i++) ln[i*BEAT_W +: BEAT_W] = beat_val(b, r, ca, i);
        line_q.push_back(ln);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (req_q.size() > 0 || line_q.size() > 0 || beat_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor and memory model, away from the active edge.
    always @(negedge clk) begin : mon
        req_t e;
        int   b;
        logic [LINE_W-1:0] exp_ln;
        if (!rst_n) begin
            beat_valid = 1'b0;
            prev_lv    = 1'b0;
        end else begin
            beat_valid = 1'b0;
            if (beat_q.size() > 0 && beat_q[0].t == cyc) begin
                beat_valid = 1'b1;
                beat_data  = beat_q[0].d;
                if (beat_q[0].last) last_beat = cyc;
                void'(beat_q.pop_front());
            end
            if (line_valid) begin
                chk(!prev_lv, "R9 line_valid one-cycle pulse", 1, 0);
                chk(cyc == last_beat + 1, "R9 line_valid cycle", cyc, last_beat + 1);
                if (line_q.size() == 0) chk(1'b0, "R9 unexpected line", 1, 0);
                else begin
                    exp_ln = line_q.pop_front();
                    chk(line_data == exp_ln, "R9 line data", line_data, exp_ln);
                end
            end
            prev_lv = line_valid;
            if (cmd_valid) begin
                b = int'(cmd_bank);
                case (cmd_kind)
                    2'd3: begin
                        pre_n[b]++;
                        pre_cyc[b] = cyc;
                    end
                    2'd1: begin
                        act_n[b]++;
                        act_cyc[b] = cyc;
                        if (pre_n[b] > 0)
                            chk(cyc - pre_cyc[b] >= T_RP, "R5 precharge-to-activate gap",
                                cyc - pre_cyc[b], T_RP);
                    end
                    2'd2: begin
                        if (req_q.size() == 0) chk(1'b0, "R8 unexpected read", 1, 0);
                        else begin
                            e = req_q.pop_front();
                            chk(b == e.bank, "R8 read order bank", b, e.bank);
                            chk(int'(cmd_row) == e.row, "R1 read row", cmd_row, e.row);
                            chk(int'(cmd_col) == e.col, "R1 aligned column", cmd_col, e.col);
                            chk(cyc - last_rd >= BURST, "R6 read spacing", cyc - last_rd, BURST);
                            if (act_n[b] > 0)
                                chk(cyc - act_cyc[b] >= T_RCD, "R3 activate-to-read gap",
                                    cyc - act_cyc[b], T_RCD);
                            case (e.cls)
                                0: chk(pre_n[b] == 0 && act_n[b] == 0, "R4 row hit commands",
                                       pre_n[b] * 10 + act_n[b], 0);
                                1: chk(pre_n[b] == 0 && act_n[b] == 1, "R2 closed bank commands",
                                       pre_n[b] * 10 + act_n[b], 1);
                                default: chk(pre_n[b] == 1 && act_n[b] == 1, "R5 row conflict commands",
                                       pre_n[b] * 10 + act_n[b], 11);
                            endcase
                        end
                        pre_n[b]  = 0;
                        act_n[b]  = 0;
                        rd_cyc[b] = cyc;
                        last_rd   = cyc;
                        for (int i = 0; i < BURST; i++)
                            beat_q.push_back('{t: cyc + RD_LAT + i,
                                               d: beat_val(b, int'(cmd_row), int'(cmd_col), i),
                                               last: (i == BURST - 1)});
                    end
                    default: chk(1'b0, "R1 unknown command code", cmd_kind, 0);
                endcase
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "R8 watchdog expired before drain", 0, 1);
        report();
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            model_row[b] = -1;
            pre_n[b] = 0; act_n[b] = 0; pre_cyc[b] = 0; act_cyc[b] = 0; rd_cyc[b] = 0;
        end
        repeat (3) @(negedge clk);
        chk(!cmd_valid, "R11 no command in reset", cmd_valid, 0);
        chk(!line_valid, "R11 line_valid low in reset", line_valid, 0);
        rst_n = 1'b1;
        #1;
        chk(req_ready, "R11 ready after reset", req_ready, 1);
        @(negedge clk);
        chk(!cmd_valid, "R11 no command after reset", cmd_valid, 0);

        // R2 closed bank, R4 hit, R5 conflict, R1 unaligned column.
        send(0, 1, 0);
        send(0, 1, 8);
        send(0, 2, 16);
        send(1, 3, 13);
        drain();

        // R7: hit on bank 0 then a closed bank 2; activation overlaps the burst.
        send(0, 2, 24);
        send(2, 5, 0);
        drain();
        chk(act_cyc[2] > rd_cyc[0] && act_cyc[2] < rd_cyc[0] + BURST,
            "R7 activate during other bank burst", act_cyc[2] - rd_cyc[0], 1);

        // R10: busy bank stalls, other bank still taken.
        send(1, 7, 0);
        req_addr = {ROW_W'(7), BANK_W'(1), COL_W'(8)};
        #1;
        chk(!req_ready, "R10 busy bank not ready", req_ready, 0);
        req_addr = {ROW_W'(4), BANK_W'(3), COL_W'(0)};
        #1;
        chk(req_ready, "R10 idle bank ready", req_ready, 1);
        send(3, 4, 0);
        send(1, 7, 8);
        drain();

        // Random traffic over three rows for hits, misses and conflicts.
        for (int k = 0; k < 80; k++) begin
            send($urandom_range(0, NB - 1), $urandom_range(0, 2), $urandom_range(0, 63));
            if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 12)) @(negedge clk);
        end
        drain();
        chk(req_q.size() == 0, "R8 every request read", req_q.size(), 0);
        chk(line_q.size() == 0, "R9 every line returned", line_q.size(), 0);
        report();
    end

endmodule